// File: doc/BRIEF.md
# Asynchronous SRAM port controller

This block sits between a clocked host and an external asynchronous static RAM of 1M words by 16 bits. The host presents one request at a time: a strobe, a direction flag, a word address, write data and a per-byte lane mask. The controller turns the request into chip-enable, write-enable, output-enable and byte-enable waveforms. It holds those waveforms for as many clock cycles as the memory's nanosecond timing needs. It also drives the shared data bus through separate in, out and enable signals.

Each timing figure is a nanosecond parameter. It is turned into a cycle count by rounding up against the clock period, with a floor of one cycle. A write keeps write enable low long enough for both the pulse width and the data setup, then holds the chip enabled to fill the full write cycle. A read keeps output enable low for the longest of the cycle time and the two access times, then latches the enabled lanes. A fixed bus-release wait follows every read before the controller may drive the bus again. The end of each request is marked by a one-cycle completion pulse.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is active and directly after it, host_ready is 1, host_done is 0, mem_ce1_n is 1, mem_ce2 is 0, mem_we_n is 1, mem_oe_n is 1, mem_be_n is all ones and mem_dq_oe is 0.
- R2: A write (host_we = 1) holds mem_ce1_n = 0, mem_ce2 = 1 and mem_we_n = 0 together for WP_CYC consecutive cycles. WP_CYC is the larger of the rounded-up write-pulse and data-setup times (8 at defaults). mem_oe_n stays 1 for the whole write, and mem_dq_oe = 1 with mem_dq_out equal to the write data.
- R3: A write keeps the chip enabled for WC_CYC cycles in total (11 at defaults): WP_CYC cycles with mem_we_n low, then the rest with mem_we_n high. mem_addr stays stable while the chip is enabled.
- R4: A read (host_we = 0) holds mem_ce1_n = 0, mem_ce2 = 1, mem_oe_n = 0 and mem_we_n = 1 for RD_CYC cycles. RD_CYC is the largest of the rounded-up read-cycle, address-access and output-enable-access times (11 at defaults). mem_dq_oe stays 0.
- R5: Lane i of host_mask covers data bits 8i+7:8i; bit 0 is the low byte and bit 1 the high byte. While the chip is enabled, mem_be_n[i] is 0 exactly when host_mask[i] was 1. While the chip is disabled, mem_be_n is all ones. Lanes that are not enabled read back as zero in host_rdata.
- R6: A request with host_mask = 00 keeps both byte enables high for its whole duration, so the memory stays deselected. Such a write changes no stored data. Such a read returns 0000 and still completes with host_done.
- R7: host_done is high for exactly one cycle per accepted request. For a write it comes in the cycle after the chip enable drops. For a read it comes in the same cycle that host_rdata takes the captured word.
- R8: After a read, mem_dq_oe stays 0 and host_ready stays 0 for TURN_CYC cycles, starting with the cycle that host_done is high (4 at defaults).
- R9: host_req is ignored while host_ready is 0. mem_addr does not change, and no extra host_done appears.
- R10: Every cycle count is ceil(ns / CLK_NS) with a minimum of 1; at CLK_NS = 5 the defaults give the counts stated above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Request strobe, taken when host_ready is 1 |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_mask | input | LANES | Per-byte lane enable, bit 0 = bits 7:0 |
| host_rdata | output | DATA_W | Captured read data, disabled lanes zero |
| host_ready | output | 1 | Idle and able to take a request |
| host_done | output | 1 | One-cycle completion pulse |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | LANES | Byte-lane enables, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data bus as seen from the memory side |

## Verification
The properties take a host that may hold host_req high while the block is busy, and a memory side whose data input carries meaning only while output enable is low. The checks on minimum write-enable width and on bus release after a read count cycles on the pins themselves, so they depend on nothing beyond those inputs. The stimulus waits for host_ready before each real request. It raises host_req with a different address only in the middle of a write. A small memory model drives marker bytes on lanes that are not enabled, so that a missing lane mask shows up in the read data.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WPULSE = 3'd1,
    ST_WREC   = 3'd2,
    ST_RACC   = 3'd3,
    ST_TURN   = 3'd4
  } sram_state_e;

  // Round a nanosecond figure up to whole clock cycles, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_port_seq.sv
module sram_port_seq
  import sram_port_pkg::*;
#(
  parameter int WP_CYC   = 8,
  parameter int REC_CYC  = 3,
  parameter int RD_CYC   = 11,
  parameter int TURN_CYC = 4,
  parameter int CNT_W    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  output sram_state_e state_n,
  output logic        accept,
  output logic        capture,
  output logic        ready,
  output logic        done
);

  sram_state_e state_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic cnt_en, last, done_n;

  assign last = (cnt_q == '0);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept  = 1'b1;
          state_n = we ? ST_WPULSE : ST_RACC;
          cnt_n   = we ? CNT_W'(WP_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
      end
      ST_WPULSE: begin
        if (last) begin
          state_n = ST_WREC;
          cnt_n   = CNT_W'(REC_CYC - 1);
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      ST_WREC: begin
        if (last) state_n = ST_IDLE;
        else      cnt_n   = cnt_q - 1'b1;
      end
      ST_RACC: begin
        if (last) begin
          capture = 1'b1;
          state_n = ST_TURN;
          cnt_n   = CNT_W'(TURN_CYC - 1);
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      ST_TURN: begin
        if (last) state_n = ST_IDLE;
        else      cnt_n   = cnt_q - 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign cnt_en = (cnt_n != cnt_q);
  assign done_n = ((state_q == ST_WREC) && last) || capture;
  assign ready  = (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_n;
      done    <= done_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/sram_port_pins.sv
module sram_port_pins
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_state_e       state_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_mask,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] host_rdata,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q, mask_n;
  logic wr_n, pulse_n, rd_n, ce_n;

  assign wr_n    = (state_n == ST_WPULSE) || (state_n == ST_WREC);
  assign pulse_n = (state_n == ST_WPULSE);
  assign rd_n    = (state_n == ST_RACC);
  assign ce_n    = wr_n || rd_n;
  assign mask_n  = accept ? host_mask : mask_q;

  // Request fields, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
      mask_q  <= host_mask;
    end
  end

  // Memory strobes come straight from flops, decoded from the next state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_be_n  <= '1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_ce1_n <= !ce_n;
      mem_ce2   <= ce_n;
      mem_we_n  <= !pulse_n;
      mem_oe_n  <= !rd_n;
      mem_be_n  <= ce_n ? ~mask_n : '1;
      mem_dq_oe <= wr_n;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        host_rdata[g*LANE_W +: LANE_W] <= '0;
      end else if (capture) begin
        host_rdata[g*LANE_W +: LANE_W] <= mask_q[g] ? mem_dq_in[g*LANE_W +: LANE_W] : '0;
      end
    end
  end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 5,
  parameter int T_WP_NS   = 40,
  parameter int T_WC_NS   = 55,
  parameter int T_DS_NS   = 25,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_OE_NS   = 25,
  parameter int T_TURN_NS = 20,
  localparam int LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_mask,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ready,
  output logic              host_done,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // R10: nanosecond figures rounded up to cycles
  localparam int WP_CYC   = max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int REC_CYC  = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
  localparam int RD_CYC   = max2(ns_to_cyc(T_RC_NS, CLK_NS),
                                 max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
  localparam int TURN_CYC = ns_to_cyc(T_TURN_NS, CLK_NS);
  localparam int MAX_CYC  = max2(max2(WP_CYC, REC_CYC), max2(RD_CYC, TURN_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic [1:0]  rst_sync_q;
  logic        rstn_s;
  sram_state_e state_n;
  logic        accept, capture;

  // Reset asserts at once, leaves two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rstn_s = rst_sync_q[1];

  sram_port_seq #(
    .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .RD_CYC(RD_CYC),
    .TURN_CYC(TURN_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rstn_s), .req(host_req), .we(host_we),
    .state_n(state_n), .accept(accept), .capture(capture),
    .ready(host_ready), .done(host_done)
  );

  sram_port_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) u_pins (
    .clk(clk), .rst_n(rstn_s), .state_n(state_n), .accept(accept),
    .capture(capture), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_mask(host_mask), .mem_dq_in(mem_dq_in), .host_rdata(host_rdata),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

endmodule

// File: rtl/sram_port_chk.sv
module sram_port_chk #(
  parameter int ADDR_W   = 20,
  parameter int LANES    = 2,
  parameter int WP_CYC   = 8,
  parameter int TURN_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic              host_done,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);

  logic [7:0] we_run_q;
  logic [7:0] turn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run_q <= '0;
      turn_q   <= '0;
    end else begin
      if (!mem_we_n) we_run_q <= (we_run_q == 8'hFF) ? we_run_q : we_run_q + 8'd1;
      else           we_run_q <= '0;
      if (!mem_oe_n)          turn_q <= 8'(TURN_CYC);
      else if (turn_q != '0)  turn_q <= turn_q - 8'd1;
    end
  end

  p_we_in_chip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_oe_n));

  p_we_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run_q >= 8'(WP_CYC)));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

  p_rd_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce1_n && mem_ce2 && mem_we_n && !mem_dq_oe));

  p_be_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce1_n |-> (mem_be_n == '1));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  p_bus_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (turn_q == '0));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ready |=> $stable(mem_addr));

endmodule

bind sram_port_ctrl sram_port_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .WP_CYC(WP_CYC), .TURN_CYC(TURN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .host_done(host_done),
  .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_port_ctrl.sv
`timescale 1ns/1ps
module test_sram_port_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [19:0] host_addr;
  logic [15:0] host_wdata;
  logic [1:0]  host_mask;
  logic [15:0] host_rdata;
  logic        host_ready, host_done;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n;
  logic [1:0]  mem_be_n;
  logic [19:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;
  logic        mem_dq_oe;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int dones  = 0;

  typedef struct { bit rd; logic [15:0] exp; } item_t;
  item_t sb_q[$];
  logic [15:0] ref_mem [logic [19:0]];
  logic [15:0] model_mem [256];

  always #2.5 clk = ~clk;

  sram_port_ctrl i_sram_port_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
    .host_rdata(host_rdata), .host_ready(host_ready), .host_done(host_done),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Memory model: writes on the rising write-enable edge, marker bytes on disabled lanes
  always @(posedge mem_we_n) begin
    if (!mem_ce1_n && mem_ce2) begin
      if (!mem_be_n[0]) model_mem[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_be_n[1]) model_mem[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
    end
  end

  assign mem_dq_in = (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) ?
    {mem_be_n[1] ? 8'hA5 : model_mem[mem_addr[7:0]][15:8],
     mem_be_n[0] ? 8'h5A : model_mem[mem_addr[7:0]][7:0]} : 16'hFFFF;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every completion
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (host_done) begin
        dones++;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R9", "completion with nothing pending", 32'(dones), 32'(pushed));
        end else begin
          item_t it;
          it = sb_q.pop_front();
          if (it.rd) chk(host_rdata == it.exp, "R5", "read data", 32'(host_rdata), 32'(it.exp));
        end
      end
      if (host_done && prev_done) chk(1'b0, "R7", "done wider than one cycle", 32'd2, 32'd1);
      prev_done = host_done;
    end
  end

  task automatic do_req(input bit wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit poke);
    item_t it;
    logic [15:0] cur;
    int n, ce_c, we_c, oe_c, dq_c, t;
    bit bad_be, bad_addr, bad_dq, bad_oe;
    while (!host_ready) @(negedge clk);
    cur = ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
    it.rd = !wr;
    it.exp = {m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00};
    if (wr) begin
      if (m[0]) cur[7:0]  = d[7:0];
      if (m[1]) cur[15:8] = d[15:8];
      ref_mem[a] = cur;
    end
    sb_q.push_back(it);
    pushed++;
    host_req = 1'b1; host_we = wr; host_addr = a; host_wdata = d; host_mask = m;
    n = 0; ce_c = 0; we_c = 0; oe_c = 0; dq_c = 0;
    bad_be = 0; bad_addr = 0; bad_dq = 0; bad_oe = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) host_req = 1'b0;
      if (poke && n == 2) begin host_req = 1'b1; host_addr = ~a; host_we = 1'b0; end
      if (poke && n == 5) host_req = 1'b0;
      if (host_done) break;
      if (!mem_ce1_n && mem_ce2) begin
        ce_c++;
        if (mem_be_n != ~m) bad_be = 1;
        if (mem_addr != a) bad_addr = 1;
      end
      if (!mem_we_n) we_c++;
      if (!mem_oe_n) begin oe_c++; if (wr) bad_oe = 1; end
      if (mem_dq_oe) begin dq_c++; if (mem_dq_out != d) bad_dq = 1; end
      if (n > 100) break;
    end
    host_req = 1'b0;
    chk(host_done == 1'b1, "R7", "completion seen", 32'(host_done), 32'd1);
    chk(!bad_be, "R6", "byte enables match mask (R5)", 32'(mem_be_n), 32'(~m));
    chk(!bad_addr, "R9", "address held through access (R3)", 32'(mem_addr), 32'(a));
    if (wr) begin
      chk(we_c == 8, "R2", "write-enable low cycles", 32'(we_c), 32'd8);
      chk(ce_c == 11, "R3", "write chip-enable cycles", 32'(ce_c), 32'd11);
      chk(dq_c == 11 && !bad_dq, "R2", "bus drive cycles", 32'(dq_c), 32'd11);
      chk(!bad_oe && oe_c == 0, "R2", "output enable during write", 32'(oe_c), 32'd0);
      chk(host_ready == 1'b1, "R7", "ready at write completion", 32'(host_ready), 32'd1);
    end else begin
      chk(oe_c == 11, "R4", "output-enable low cycles", 32'(oe_c), 32'd11);
      chk(ce_c == 11 && we_c == 0 && dq_c == 0, "R4", "read strobes",
          32'(ce_c), 32'd11);
      t = 0;
      while (!host_ready && t < 50) begin
        if (mem_dq_oe) chk(1'b0, "R8", "bus driven in release window", 32'd1, 32'd0);
        t++;
        @(negedge clk);
      end
      chk(t == 4, "R8", "release window cycles", 32'(t), 32'd4);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model_mem[i] = 16'h0000;
    host_req = 0; host_we = 0; host_addr = '0; host_wdata = '0; host_mask = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(host_ready && !host_done && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n
        && mem_be_n == 2'b11 && !mem_dq_oe, "R1", "idle pins in reset",
        {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 32'b1011110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(host_ready && !host_done && mem_ce1_n && mem_we_n && mem_oe_n && !mem_dq_oe,
        "R1", "idle pins after reset", 32'(host_ready), 32'd1);

    // R2 R3 R4 R10: full word write and read back with default counts
    do_req(1, 20'h00010, 16'h1234, 2'b11, 0);
    do_req(0, 20'h00010, 16'h0000, 2'b11, 0);
    // R5: single-lane writes merge into the stored word
    do_req(1, 20'h00010, 16'hABCD, 2'b01, 0);
    do_req(0, 20'h00010, 16'h0000, 2'b11, 0);
    do_req(1, 20'h00010, 16'h5678, 2'b10, 0);
    do_req(0, 20'h00010, 16'h0000, 2'b01, 0);
    do_req(0, 20'h00010, 16'h0000, 2'b10, 0);
    // R6: empty mask writes nothing and reads zero
    do_req(1, 20'h00010, 16'hFFFF, 2'b00, 0);
    do_req(0, 20'h00010, 16'h0000, 2'b11, 0);
    do_req(0, 20'h00010, 16'h0000, 2'b00, 0);
    // R9: requests raised mid-write are ignored
    do_req(1, 20'hFFFFF, 16'hBEEF, 2'b11, 1);
    repeat (6) @(negedge clk);
    chk(dones == pushed, "R9", "completions after busy request", 32'(dones), 32'(pushed));
    do_req(0, 20'hFFFFF, 16'h0000, 2'b11, 0);
    // R8: read followed at once by a write
    for (int i = 0; i < 6; i++) begin
      do_req(1, 20'(32'h30020 + i * 32'h1001), 16'(16'h1111 * (i + 1) ^ 16'h0F0F), 2'b11, 0);
      do_req(0, 20'(32'h30020 + i * 32'h1001), 16'h0000, 2'b11, 0);
    end
    repeat (4) @(negedge clk);
    chk(dones == pushed && sb_q.size() == 0, "R7", "one completion per request",
        32'(dones), 32'(pushed));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule